// File: doc/BRIEF.md
# UART Interrupt Source Arbiter

This block sits beside one serial channel and decides which of its seven interrupt conditions the processor sees. Three conditions are levels that the receive side holds for as long as they are true. The other four arrive as one-cycle event pulses and are kept in sticky flags until their own clear action occurs. Each condition is gated by its bit of an enable vector. The highest-ranked enabled condition is reported as a six-bit identification code, and the interrupt pin is active while any enabled condition is pending.

The identification value is frozen while a read of it is under way. A read can also clear a source: the transmit-empty, Xoff and flow-change flags are cleared when a read reports them. A write to the transmit holding register clears the transmit-empty flag. A read of the modem status register clears the modem flag.

Top module: `uart_irq_encoder`

## Requirements
- R1: The enabled pending source that ranks highest is reported on `iir_o[5:0]`. Rank, highest first, with enable bit and code: line error (bit 0, 0x06), receive time-out (bit 1, 0x0C), receive data at trigger (bit 2, 0x04), transmit holding empty (bit 3, 0x02), modem change (bit 4, 0x00), Xoff/special character (bit 5, 0x10), CTS/RTS change (bit 6, 0x20).
- R2: With no enabled source pending, `iir_o` reads 0x01. Bit 0 reads 0 whenever a source is reported.
- R3: A source whose enable bit is 0 is neither reported nor drives the pin. With all enable bits 0 the pin stays inactive. An event that arrives while its enable bit is 0 is still held, and it is reported once the bit is set.
- R4: `irq_o` is active whenever any enabled source is pending. The default polarity is active high, and the pin is low when nothing is pending.
- R5: The three level sources follow their inputs with no storage, so each one stops being reported in the cycle its input falls.
- R6: Reading `iir_o` clears the Xoff and CTS/RTS-change flags only when that read reports them. A read that reports a higher source leaves them set.
- R7: The transmit-empty flag is cleared by a `thr_wr_i` strobe, or by an `iir_o` read that reports it.
- R8: The modem flag is cleared only by `msr_rd_i`. A read of `iir_o` does not clear it.
- R9: During a read (`iir_rd_i` high), `iir_o` holds the value present in the cycle the strobe rose, even if sources change. The live value returns one cycle after the strobe falls.
- R10: After reset, all event flags are clear.
- R11: If an event pulse and its clear action occur in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ien_i | input | 7 | Per-source enable vector (bit positions in R1) |
| lsr_err_i | input | 1 | Receiver line error condition (level) |
| rx_tmo_i | input | 1 | Receive time-out condition (level) |
| rx_trig_i | input | 1 | Receive FIFO at or above trigger (level) |
| thr_empty_set_i | input | 1 | Transmit holding register became empty (pulse) |
| modem_set_i | input | 1 | Modem input change seen (pulse) |
| xoff_set_i | input | 1 | Xoff or special character received (pulse) |
| flow_set_i | input | 1 | CTS or RTS changed state (pulse) |
| thr_wr_i | input | 1 | Transmit holding register write strobe |
| msr_rd_i | input | 1 | Modem status register read strobe |
| iir_rd_i | input | 1 | Identification register read, high for the read cycle |
| iir_o | output | ID_W (6) | Identification value |
| irq_o | output | 1 | Interrupt pin |

## Verification
A flag that is wrongly set or cleared shows on `iir_o` as a wrong or missing code, at the latest one cycle after the pulse or strobe responsible. The pin disagrees with bit 0 in the same cycle. A broken priority chain reports a lower code while a higher enabled level is held. A broken read freeze lets `iir_o` move in the second cycle of a read. A clear that hits the wrong source shows up after the read, when the next code in line is missing or a stale one reappears.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   localparam int NSRC     = 7;
   localparam int CODE_W   = 6;
   localparam int SRC_LSR  = 0;
   localparam int SRC_TMO  = 1;
   localparam int SRC_RXD  = 2;
   localparam int SRC_THR  = 3;
   localparam int SRC_MDM  = 4;
   localparam int SRC_XOFF = 5;
   localparam int SRC_FLOW = 6;
   // sources held in sticky flags; the rest are live levels
   localparam logic [NSRC-1:0] EVT_MASK = 7'b111_1000;
   localparam logic [CODE_W-1:0] CODE_IDLE = 6'h01;

   function automatic logic [CODE_W-1:0] src_code(input int idx);
      case (idx)
         SRC_LSR:  return 6'h06;
         SRC_TMO:  return 6'h0C;
         SRC_RXD:  return 6'h04;
         SRC_THR:  return 6'h02;
         SRC_MDM:  return 6'h00;
         SRC_XOFF: return 6'h10;
         SRC_FLOW: return 6'h20;
         default:  return CODE_IDLE;
      endcase
   endfunction
endpackage

// File: rtl/uart_irq_evt_latch.sv
module uart_irq_evt_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   // a new event outranks a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_o <= 1'b0;
      else if (set_i)  q_o <= 1'b1;
      else if (clr_i)  q_o <= 1'b0;
   end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
   import uart_irq_pkg::*;
(
   input  logic [NSRC-1:0]   req_i,
   output logic [NSRC-1:0]   grant_o,
   output logic [CODE_W-1:0] code_o
);
   // index 0 ranks highest: walk from the lowest rank upward, last hit wins
   always_comb begin
      grant_o = '0;
      code_o  = CODE_IDLE;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            grant_o    = '0;
            grant_o[i] = 1'b1;
            code_o     = src_code(i);
         end
      end
   end
endmodule

// File: rtl/uart_irq_encoder.sv
module uart_irq_encoder
   import uart_irq_pkg::*;
#(
   parameter int ID_W           = 6,
   parameter bit IRQ_ACTIVE_LOW = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [6:0]      ien_i,
   input  logic            lsr_err_i,
   input  logic            rx_tmo_i,
   input  logic            rx_trig_i,
   input  logic            thr_empty_set_i,
   input  logic            modem_set_i,
   input  logic            xoff_set_i,
   input  logic            flow_set_i,
   input  logic            thr_wr_i,
   input  logic            msr_rd_i,
   input  logic            iir_rd_i,
   output logic [ID_W-1:0] iir_o,
   output logic            irq_o
);
   localparam int PAD_W = (ID_W > CODE_W) ? ID_W - CODE_W : 1;

   if (ID_W < CODE_W) begin : g_bad_width
      $error("uart_irq_encoder: ID_W must be at least 6");
   end

   logic [NSRC-1:0]   lvl_vec, set_vec, clr_vec, raw, pend, grant;
   logic [CODE_W-1:0] live_code, snap_code, shown_code;
   logic              rd_q, rd_start;

   assign rd_start = iir_rd_i & ~rd_q;

   always_comb begin
      lvl_vec           = '0;
      lvl_vec[SRC_LSR]  = lsr_err_i;
      lvl_vec[SRC_TMO]  = rx_tmo_i;
      lvl_vec[SRC_RXD]  = rx_trig_i;
      set_vec           = '0;
      set_vec[SRC_THR]  = thr_empty_set_i;
      set_vec[SRC_MDM]  = modem_set_i;
      set_vec[SRC_XOFF] = xoff_set_i;
      set_vec[SRC_FLOW] = flow_set_i;
      clr_vec           = '0;
      clr_vec[SRC_THR]  = thr_wr_i | (rd_start & grant[SRC_THR]);
      clr_vec[SRC_MDM]  = msr_rd_i;
      clr_vec[SRC_XOFF] = rd_start & grant[SRC_XOFF];
      clr_vec[SRC_FLOW] = rd_start & grant[SRC_FLOW];
   end

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      if (EVT_MASK[i]) begin : g_evt
         uart_irq_evt_latch u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_vec[i]),
            .clr_i (clr_vec[i]),
            .q_o   (raw[i])
         );
      end else begin : g_lvl
         assign raw[i] = lvl_vec[i];
      end
   end

   assign pend = raw & ien_i;

   uart_irq_prio u_prio (
      .req_i   (pend),
      .grant_o (grant),
      .code_o  (live_code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q      <= 1'b0;
         snap_code <= CODE_IDLE;
      end else begin
         rd_q <= iir_rd_i;
         if (rd_start) snap_code <= live_code;
      end
   end

   assign shown_code = rd_q ? snap_code : live_code;

   if (ID_W > CODE_W) begin : g_pad
      assign iir_o = {{PAD_W{1'b0}}, shown_code};
   end else begin : g_nopad
      assign iir_o = shown_code;
   end

   if (IRQ_ACTIVE_LOW) begin : g_irq_low
      assign irq_o = ~(|pend);
   end else begin : g_irq_high
      assign irq_o = |pend;
   end
endmodule

// File: rtl/uart_irq_encoder_chk.sv
module uart_irq_encoder_chk #(
   parameter int ID_W           = 6,
   parameter bit IRQ_ACTIVE_LOW = 1'b0
) (
   input logic            clk,
   input logic            rst_n,
   input logic [6:0]      ien_i,
   input logic            lsr_err_i,
   input logic            thr_empty_set_i,
   input logic            modem_set_i,
   input logic            thr_wr_i,
   input logic            msr_rd_i,
   input logic            iir_rd_i,
   input logic [ID_W-1:0] iir_o,
   input logic            irq_o
);
   logic irq_act;
   assign irq_act = irq_o ^ IRQ_ACTIVE_LOW;

   assert_prio_lsr_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_err_i && ien_i[0] && !$past(iir_rd_i)) |-> (iir_o[5:0] == 6'h06));

   assert_idle_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_act && !$past(iir_rd_i)) |-> (iir_o[5:0] == 6'h01));

   assert_mask_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_i == 7'h00) |-> !irq_act);

   assert_irq_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(iir_rd_i) |-> (irq_act == !iir_o[0]));

   assert_thr_wr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(thr_wr_i) && !$past(thr_empty_set_i) && !$past(iir_rd_i))
      |-> (iir_o[5:0] != 6'h02));

   assert_msr_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(msr_rd_i) && !$past(modem_set_i) && !$past(iir_rd_i))
      |-> (iir_o[5:0] != 6'h00));

   assert_snap_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(iir_rd_i) && $past(iir_rd_i, 2)) |-> $stable(iir_o));
endmodule

bind uart_irq_encoder uart_irq_encoder_chk #(
   .ID_W           (ID_W),
   .IRQ_ACTIVE_LOW (IRQ_ACTIVE_LOW)
) i_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .ien_i           (ien_i),
   .lsr_err_i       (lsr_err_i),
   .thr_empty_set_i (thr_empty_set_i),
   .modem_set_i     (modem_set_i),
   .thr_wr_i        (thr_wr_i),
   .msr_rd_i        (msr_rd_i),
   .iir_rd_i        (iir_rd_i),
   .iir_o           (iir_o),
   .irq_o           (irq_o)
);

// File: tb/test_uart_irq_encoder.sv
`timescale 1ns/1ps
module test_uart_irq_encoder;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] ien = 7'h7F;
   logic       lsr = 0, tmo = 0, rxd = 0;
   logic       thr_set = 0, mdm_set = 0, xoff_set = 0, flow_set = 0;
   logic       thr_wr = 0, msr_rd = 0, iir_rd = 0;
   logic [5:0] iir;
   logic       irq;
   int         n_cmp = 0, n_bad = 0;
   bit         done = 0;

   always #2.5 clk = ~clk;

   uart_irq_encoder i_uart_irq_encoder (
      .clk(clk), .rst_n(rst_n), .ien_i(ien),
      .lsr_err_i(lsr), .rx_tmo_i(tmo), .rx_trig_i(rxd),
      .thr_empty_set_i(thr_set), .modem_set_i(mdm_set),
      .xoff_set_i(xoff_set), .flow_set_i(flow_set),
      .thr_wr_i(thr_wr), .msr_rd_i(msr_rd), .iir_rd_i(iir_rd),
      .iir_o(iir), .irq_o(irq)
   );

   // {enable, levels {rxd,tmo,lsr}, events {flow,xoff,mdm,thr}, expected code}
   localparam logic [19:0] VEC [14] = '{
      {7'h7F, 3'b001, 4'b1111, 6'h06},
      {7'h7F, 3'b010, 4'b1111, 6'h0C},
      {7'h7F, 3'b100, 4'b1111, 6'h04},
      {7'h7F, 3'b000, 4'b1111, 6'h02},
      {7'h7F, 3'b000, 4'b1110, 6'h00},
      {7'h7F, 3'b000, 4'b1100, 6'h10},
      {7'h7F, 3'b000, 4'b1000, 6'h20},
      {7'h7F, 3'b000, 4'b0000, 6'h01},
      {7'h7E, 3'b001, 4'b0000, 6'h01},
      {7'h7E, 3'b011, 4'b0000, 6'h0C},
      {7'h00, 3'b111, 4'b1111, 6'h01},
      {7'h77, 3'b000, 4'b1111, 6'h00},
      {7'h40, 3'b000, 4'b1111, 6'h20},
      {7'h08, 3'b111, 4'b1111, 6'h02}
   };

   task automatic chk(input string rq, input logic [5:0] act, input logic [5:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   task automatic pulse_evt(input logic [3:0] e);
      @(negedge clk);
      {flow_set, xoff_set, mdm_set, thr_set} = e;
      @(negedge clk);
      {flow_set, xoff_set, mdm_set, thr_set} = 4'b0;
   endtask

   task automatic iir_read(output logic [5:0] v);
      @(negedge clk); iir_rd = 1;
      @(negedge clk); v = iir; iir_rd = 0;
      @(negedge clk);
   endtask

   task automatic clean_all();
      logic [5:0] d;
      ien = 7'h7F; {rxd, tmo, lsr} = 3'b0;
      @(negedge clk); thr_wr = 1; msr_rd = 1;
      @(negedge clk); thr_wr = 0; msr_rd = 0;
      for (int k = 0; k < 3; k++) iir_read(d);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [5:0] v, v2;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R10 reset code", iir, 6'h01);
      chk("R10 reset pin", {5'b0, irq}, 6'h00);

      // table walk: R1 priority, R2 idle, R3 masking, R4 pin
      for (int i = 0; i < 14; i++) begin
         clean_all();
         ien = VEC[i][19:13];
         pulse_evt(VEC[i][9:6]);
         {rxd, tmo, lsr} = VEC[i][12:10];
         @(negedge clk);
         chk($sformatf("R1/R3 vector %0d code", i), iir, VEC[i][5:0]);
         chk($sformatf("R4 vector %0d pin", i), {5'b0, irq}, {5'b0, VEC[i][5:0] != 6'h01});
      end

      // R5: level source drops out at once
      clean_all(); tmo = 1; @(negedge clk);
      chk("R5 level held", iir, 6'h0C);
      tmo = 0; #1;
      chk("R5 level gone", iir, 6'h01);

      // R6: Xoff cleared by a read that reports it
      clean_all(); pulse_evt(4'b0100); iir_read(v);
      chk("R6 xoff read value", v, 6'h10);
      chk("R6 xoff cleared", iir, 6'h01);
      // R6: not cleared when a higher source is reported
      clean_all(); pulse_evt(4'b1000); lsr = 1; iir_read(v);
      chk("R6 flow masked read", v, 6'h06);
      lsr = 0; #1;
      chk("R6 flow kept", iir, 6'h20);
      iir_read(v);
      chk("R6 flow cleared", iir, 6'h01);

      // R7: transmit-empty clears
      clean_all(); pulse_evt(4'b0001);
      @(negedge clk); thr_wr = 1; @(negedge clk); thr_wr = 0;
      chk("R7 thr write clear", iir, 6'h01);
      pulse_evt(4'b0001); iir_read(v);
      chk("R7 thr read value", v, 6'h02);
      chk("R7 thr read clear", iir, 6'h01);

      // R8: modem only cleared by status read
      clean_all(); pulse_evt(4'b0010); iir_read(v);
      chk("R8 modem read value", v, 6'h00);
      chk("R8 modem survives iir read", iir, 6'h00);
      @(negedge clk); msr_rd = 1; @(negedge clk); msr_rd = 0;
      chk("R8 modem cleared", iir, 6'h01);

      // R9: frozen during read
      clean_all(); pulse_evt(4'b0001);
      @(negedge clk); iir_rd = 1;
      @(negedge clk); v = iir; lsr = 1;
      @(negedge clk); v2 = iir;
      chk("R9 snapshot first", v, 6'h02);
      chk("R9 snapshot held", v2, 6'h02);
      chk("R4 pin during read", {5'b0, irq}, 6'h01);
      iir_rd = 0; @(negedge clk);
      chk("R9 live after read", iir, 6'h06);
      lsr = 0; #1;
      chk("R9 read cleared thr", iir, 6'h01);

      // R3: event held while masked
      clean_all(); ien = 7'h77; pulse_evt(4'b0001); @(negedge clk);
      chk("R3 masked thr hidden", iir, 6'h01);
      ien = 7'h7F; #1;
      chk("R3 masked thr kept", iir, 6'h02);

      // R11: set beats clear
      clean_all();
      @(negedge clk); thr_set = 1; thr_wr = 1;
      @(negedge clk); thr_set = 0; thr_wr = 0;
      chk("R11 set wins", iir, 6'h02);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule